// File: doc/BRIEF.md
# PTP Frame Detector and Field Extractor

This block listens to a byte-wide Ethernet data stream, one byte per clock while the data-valid input is high. It works out whether each frame carries an IEEE 1588 message. It recognises three carriers: PTP placed straight in the Ethernet payload, PTP inside UDP over IPv4, and PTP inside UDP over IPv6. Each of these may sit behind zero, one or two stacked VLAN tags.

The first byte presented in a frame is the first destination MAC byte. No preamble or start delimiter is presented. A frame ends when data-valid goes low, and the next frame begins with the next byte that has data-valid high. When a frame qualifies and its sequence ID has been fully received, the block raises a single-cycle detect pulse. With the pulse it presents the message type, the sequence ID, the carrier class and the number of VLAN tags crossed. A nearby timestamp unit pairs these with the time it captured at start of frame. CRC checking, IPv4 options and timestamp generation are left to other blocks.

Top module: `ptp_frame_sniffer`

## Requirements
- R1: While reset is asserted, and after it is released, det_pulse is 0 and det_msg_type, det_seq_id, det_encap and det_tags are all 0 until the first detection.
- R2: A frame whose ethertype (the two bytes after the 12 MAC address bytes, high byte first) is 0x88F7 is treated as PTP whose header starts right after the ethertype, and it is reported with det_encap = 0.
- R3: Each ethertype 0x8100 is a VLAN tag that moves the real ethertype 4 bytes later. Up to MAX_TAGS (2) tags are crossed and det_tags reports how many. A frame with a further 0x8100 after MAX_TAGS tags is never detected.
- R4: Ethertype 0x0800 selects IPv4. The first IP byte must be 0x45 and the byte at IP offset 9 must be 17. UDP then starts at IP offset 20, and the frame is reported with det_encap = 1. Any other first IP byte or protocol value means no detection.
- R5: Ethertype 0x86DD selects IPv6. The byte at IP offset 6 must be 17. UDP then starts at IP offset 40, and the frame is reported with det_encap = 2. Any other next-header value means no detection.
- R6: For UDP carriers, the destination port (UDP bytes 2 and 3, high byte first) must be 319 or 320. Any other port means no detection. The PTP header starts at UDP offset 8.
- R7: det_msg_type is the low 4 bits of PTP header byte 0. det_seq_id is PTP header byte 30 (high) and byte 31 (low).
- R8: det_pulse is high for exactly one cycle, in the cycle after the clock edge that takes in PTP header byte 31. The output fields change only with a pulse and otherwise hold their values.
- R9: A frame that ends before PTP header byte 31 is taken in is not detected, and neither is a frame with any other ethertype. A frame that ends exactly after byte 31 is detected.
- R10: Each frame produces at most one pulse. Frames separated by a single idle cycle are each parsed from their own first byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_dv | input | 1 | Byte valid; low between frames |
| rx_byte | input | 8 | Stream byte, first byte of a frame is the first destination MAC byte |
| det_pulse | output | 1 | One-cycle detection pulse |
| det_msg_type | output | 4 | Message type of the detected frame |
| det_seq_id | output | 16 | Sequence ID of the detected frame |
| det_encap | output | 2 | Carrier class: 0 Ethernet, 1 IPv4/UDP, 2 IPv6/UDP |
| det_tags | output | TAG_W (2) | Number of VLAN tags crossed |

## Verification
Each parsing stage counts its own bytes relative to where the stage before it handed over. If a stage starts one byte late or early, a missed or shifted offset shows up in the same frame. The sequence ID comes out byte-swapped or displaced, or the pulse lands one cycle off from 32 cycles after the PTP header start. A stage stuck busy after a frame ends would show in the next frame as a missing pulse or a pulse on a non-PTP frame. Frames separated by a single idle cycle catch this within one frame time. Errors in counting VLAN tags show up directly on det_tags, and on the pulse timing, which moves 4 cycles per tag.

// File: rtl/ptp_sniff_pkg.sv
// Package: shared carrier class type and protocol constants for the PTP
// frame detector. Assumes byte offsets are counted from segment starts.
package ptp_sniff_pkg;

    typedef enum logic [1:0] {
        ENC_L2   = 2'd0,
        ENC_IP4  = 2'd1,
        ENC_IP6  = 2'd2,
        ENC_NONE = 2'd3
    } encap_e;

    localparam logic [15:0] ET_VLAN   = 16'h8100;
    localparam logic [15:0] ET_PTP    = 16'h88F7;
    localparam logic [15:0] ET_IP4    = 16'h0800;
    localparam logic [15:0] ET_IP6    = 16'h86DD;

    localparam logic [7:0]  IP4_VIHL  = 8'h45;
    localparam logic [7:0]  PROTO_UDP = 8'd17;
    localparam logic [15:0] PORT_EVT  = 16'd319;
    localparam logic [15:0] PORT_GEN  = 16'd320;

    localparam int MAC_ADDR_BYTES = 12;
    localparam int TAG_BYTES      = 4;
    localparam int IP4_HDR_BYTES  = 20;
    localparam int IP4_PROTO_OFS  = 9;
    localparam int IP6_HDR_BYTES  = 40;
    localparam int IP6_NXT_OFS    = 6;
    localparam int UDP_HDR_BYTES  = 8;
    localparam int UDP_DPORT_OFS  = 2;
    localparam int PTP_SEQ_OFS    = 30;

endpackage

// File: rtl/psn_eth_walker.sv
// Ethernet header walker: counts bytes from frame start, reads the ethertype,
// crosses up to MAX_TAGS VLAN tags and hands over to the next stage with a
// registered one-cycle pulse that is high while the next segment's byte 0 is
// on the bus. Assumes rx_dv stays high for the whole frame.
module psn_eth_walker
    import ptp_sniff_pkg::*;
#(
    parameter int MAX_TAGS = 2,
    localparam int TAG_W = (MAX_TAGS < 1) ? 1 : $clog2(MAX_TAGS + 1),
    localparam int POS_W = $clog2(MAC_ADDR_BYTES + TAG_BYTES * MAX_TAGS + 2) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_dv,
    input  logic [7:0]       in_byte,
    output logic             go_l2,
    output logic             go_ip4,
    output logic             go_ip6,
    output encap_e           frame_encap,
    output logic [TAG_W-1:0] frame_tags
);

    localparam logic [POS_W-1:0] POS_MAX  = '1;
    localparam logic [POS_W-1:0] POS_BASE = POS_W'(MAC_ADDR_BYTES);

    logic             dv_q;
    logic             busy;
    logic [POS_W-1:0] pos;
    logic [7:0]       et_hi;
    logic [TAG_W-1:0] tags;

    logic             frame_first;
    logic             looking;
    logic [POS_W-1:0] cur_pos;
    logic [POS_W-1:0] type_pos;
    logic [15:0]      et;
    logic             at_hi;
    logic             at_lo;

    // Purpose: locate the current byte and the expected ethertype position.
    always_comb begin
        frame_first = in_dv & ~dv_q;
        looking     = in_dv & (frame_first | busy);
        cur_pos     = frame_first ? '0 : pos;
        type_pos    = POS_BASE + POS_W'({tags, 2'b00});
        et          = {et_hi, in_byte};
        at_hi       = looking && (cur_pos == type_pos);
        at_lo       = looking && !frame_first && (cur_pos == type_pos + 1'b1);
    end

    // Purpose: track frame position, tags and issue handover pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dv_q        <= 1'b0;
            busy        <= 1'b0;
            pos         <= '0;
            et_hi       <= '0;
            tags        <= '0;
            go_l2       <= 1'b0;
            go_ip4      <= 1'b0;
            go_ip6      <= 1'b0;
            frame_encap <= ENC_NONE;
        end else begin
            dv_q   <= in_dv;
            go_l2  <= 1'b0;
            go_ip4 <= 1'b0;
            go_ip6 <= 1'b0;
            if (!in_dv) begin
                busy <= 1'b0;
            end else begin
                if (cur_pos != POS_MAX) begin
                    pos <= cur_pos + 1'b1;
                end
                if (frame_first) begin
                    busy        <= 1'b1;
                    tags        <= '0;
                    frame_encap <= ENC_NONE;
                end
                if (at_hi) begin
                    et_hi <= in_byte;
                end
                if (at_lo) begin
                    if (et == ET_VLAN && tags < TAG_W'(MAX_TAGS)) begin
                        tags <= tags + 1'b1;
                    end else begin
                        busy <= 1'b0;
                        case (et)
                            ET_PTP: begin
                                go_l2       <= 1'b1;
                                frame_encap <= ENC_L2;
                            end
                            ET_IP4: begin
                                go_ip4      <= 1'b1;
                                frame_encap <= ENC_IP4;
                            end
                            ET_IP6: begin
                                go_ip6      <= 1'b1;
                                frame_encap <= ENC_IP6;
                            end
                            default: frame_encap <= ENC_NONE;
                        endcase
                    end
                end
            end
        end
    end

    assign frame_tags = tags;

endmodule

// File: rtl/psn_ip_udp.sv
// IP and UDP header checker: starts on a handover pulse for IPv4 or IPv6,
// checks the fixed-length IP header and the UDP destination port, and pulses
// go_ptp while the first PTP header byte is on the bus. Assumes a 20-byte
// IPv4 header with no options.
module psn_ip_udp
    import ptp_sniff_pkg::*;
#(
    localparam int IDX_W = $clog2(IP6_HDR_BYTES)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_dv,
    input  logic [7:0] in_byte,
    input  logic       go_ip4,
    input  logic       go_ip6,
    output logic       go_ptp
);

    localparam logic [IDX_W-1:0] IX_V4_PROTO = IDX_W'(IP4_PROTO_OFS);
    localparam logic [IDX_W-1:0] IX_V4_LAST  = IDX_W'(IP4_HDR_BYTES - 1);
    localparam logic [IDX_W-1:0] IX_V6_NXT   = IDX_W'(IP6_NXT_OFS);
    localparam logic [IDX_W-1:0] IX_V6_LAST  = IDX_W'(IP6_HDR_BYTES - 1);
    localparam logic [IDX_W-1:0] IX_PORT_HI  = IDX_W'(UDP_DPORT_OFS);
    localparam logic [IDX_W-1:0] IX_PORT_LO  = IDX_W'(UDP_DPORT_OFS + 1);
    localparam logic [IDX_W-1:0] IX_UDP_LAST = IDX_W'(UDP_HDR_BYTES - 1);

    typedef enum logic [1:0] {S_IDLE, S_IP4, S_IP6, S_UDP} seg_e;

    seg_e             st;
    seg_e             cur_st;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] cur_idx;
    logic [7:0]       port_hi;
    logic             fail;
    logic             last;

    // Purpose: pick the live segment and judge the current byte.
    always_comb begin
        cur_st  = go_ip4 ? S_IP4 : (go_ip6 ? S_IP6 : st);
        cur_idx = (go_ip4 | go_ip6) ? '0 : idx;
        fail    = 1'b0;
        last    = 1'b0;
        case (cur_st)
            S_IP4: begin
                if (cur_idx == '0 && in_byte != IP4_VIHL) fail = 1'b1;
                if (cur_idx == IX_V4_PROTO && in_byte != PROTO_UDP) fail = 1'b1;
                last = (cur_idx == IX_V4_LAST);
            end
            S_IP6: begin
                if (cur_idx == IX_V6_NXT && in_byte != PROTO_UDP) fail = 1'b1;
                last = (cur_idx == IX_V6_LAST);
            end
            S_UDP: begin
                if (cur_idx == IX_PORT_HI &&
                    in_byte != PORT_EVT[15:8] && in_byte != PORT_GEN[15:8]) fail = 1'b1;
                if (cur_idx == IX_PORT_LO &&
                    {port_hi, in_byte} != PORT_EVT &&
                    {port_hi, in_byte} != PORT_GEN) fail = 1'b1;
                last = (cur_idx == IX_UDP_LAST);
            end
            default: ;
        endcase
    end

    // Purpose: step through IP and UDP segments and flag the PTP start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            idx     <= '0;
            port_hi <= '0;
            go_ptp  <= 1'b0;
        end else begin
            go_ptp <= 1'b0;
            if (!in_dv) begin
                st <= S_IDLE;
            end else if (cur_st != S_IDLE) begin
                if (cur_st == S_UDP && cur_idx == IX_PORT_HI) begin
                    port_hi <= in_byte;
                end
                if (fail) begin
                    st <= S_IDLE;
                end else if (last) begin
                    idx <= '0;
                    if (cur_st == S_UDP) begin
                        st     <= S_IDLE;
                        go_ptp <= 1'b1;
                    end else begin
                        st <= S_UDP;
                    end
                end else begin
                    st  <= cur_st;
                    idx <= cur_idx + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/psn_ptp_grab.sv
// PTP header field grabber: starts when a handover pulse marks PTP byte 0,
// keeps the message type, collects the sequence ID and publishes all fields
// with a one-cycle pulse. Assumes rx_dv low means the frame has ended.
module psn_ptp_grab
    import ptp_sniff_pkg::*;
#(
    parameter int TAG_W = 2,
    localparam int IDX_W = $clog2(PTP_SEQ_OFS + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_dv,
    input  logic [7:0]       in_byte,
    input  logic             start,
    input  encap_e           enc_in,
    input  logic [TAG_W-1:0] tags_in,
    output logic             hit,
    output logic [3:0]       msg_type,
    output logic [15:0]      seq_id,
    output encap_e           enc_out,
    output logic [TAG_W-1:0] tags_out
);

    localparam logic [IDX_W-1:0] IX_SEQ_HI = IDX_W'(PTP_SEQ_OFS);
    localparam logic [IDX_W-1:0] IX_SEQ_LO = IDX_W'(PTP_SEQ_OFS + 1);

    logic             active;
    logic [IDX_W-1:0] idx;
    logic [3:0]       mt_q;
    logic [7:0]       seq_hi;
    logic             cur_act;
    logic [IDX_W-1:0] cur_idx;

    // Purpose: decide whether the current byte belongs to a PTP header.
    always_comb begin
        cur_act = in_dv & (start | active);
        cur_idx = start ? '0 : idx;
    end

    // Purpose: capture header fields and publish them on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            idx      <= '0;
            mt_q     <= '0;
            seq_hi   <= '0;
            hit      <= 1'b0;
            msg_type <= '0;
            seq_id   <= '0;
            enc_out  <= ENC_L2;
            tags_out <= '0;
        end else begin
            hit <= 1'b0;
            if (!cur_act) begin
                active <= 1'b0;
            end else begin
                if (cur_idx == '0) begin
                    mt_q <= in_byte[3:0];
                end
                if (cur_idx == IX_SEQ_HI) begin
                    seq_hi <= in_byte;
                end
                if (cur_idx == IX_SEQ_LO) begin
                    active   <= 1'b0;
                    hit      <= 1'b1;
                    msg_type <= mt_q;
                    seq_id   <= {seq_hi, in_byte};
                    enc_out  <= enc_in;
                    tags_out <= tags_in;
                end else begin
                    active <= 1'b1;
                    idx    <= cur_idx + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ptp_frame_sniffer.sv
// Top of the PTP frame detector: chains the Ethernet walker, the IP/UDP
// checker and the PTP field grabber. Assumes a continuous byte stream per
// frame starting at the destination MAC, with rx_dv low between frames.
module ptp_frame_sniffer
    import ptp_sniff_pkg::*;
#(
    parameter int MAX_TAGS = 2,
    localparam int TAG_W = (MAX_TAGS < 1) ? 1 : $clog2(MAX_TAGS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_dv,
    input  logic [7:0]       rx_byte,
    output logic             det_pulse,
    output logic [3:0]       det_msg_type,
    output logic [15:0]      det_seq_id,
    output logic [1:0]       det_encap,
    output logic [TAG_W-1:0] det_tags
);

    logic             go_l2;
    logic             go_ip4;
    logic             go_ip6;
    logic             go_ptp;
    logic             ptp_start;
    encap_e           frame_encap;
    encap_e           hit_encap;
    logic [TAG_W-1:0] frame_tags;

    psn_eth_walker #(.MAX_TAGS(MAX_TAGS)) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_dv       (rx_dv),
        .in_byte     (rx_byte),
        .go_l2       (go_l2),
        .go_ip4      (go_ip4),
        .go_ip6      (go_ip6),
        .frame_encap (frame_encap),
        .frame_tags  (frame_tags)
    );

    psn_ip_udp u_ipudp (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_dv   (rx_dv),
        .in_byte (rx_byte),
        .go_ip4  (go_ip4),
        .go_ip6  (go_ip6),
        .go_ptp  (go_ptp)
    );

    assign ptp_start = go_l2 | go_ptp;

    psn_ptp_grab #(.TAG_W(TAG_W)) u_grab (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_dv    (rx_dv),
        .in_byte  (rx_byte),
        .start    (ptp_start),
        .enc_in   (frame_encap),
        .tags_in  (frame_tags),
        .hit      (det_pulse),
        .msg_type (det_msg_type),
        .seq_id   (det_seq_id),
        .enc_out  (hit_encap),
        .tags_out (det_tags)
    );

    assign det_encap = hit_encap;

endmodule

// File: rtl/psn_checker.sv
// Checker for the PTP frame detector: properties on the output pulse, the
// held fields and the handover pulses between stages. Bound to the top.
module psn_checker #(
    parameter int MAX_TAGS = 2,
    localparam int TAG_W = (MAX_TAGS < 1) ? 1 : $clog2(MAX_TAGS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_dv,
    input logic             det_pulse,
    input logic [3:0]       det_msg_type,
    input logic [15:0]      det_seq_id,
    input logic [1:0]       det_encap,
    input logic [TAG_W-1:0] det_tags,
    input logic             go_l2,
    input logic             go_ip4,
    input logic             go_ip6,
    input logic             go_ptp
);

    p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        det_pulse |=> !det_pulse);

    p_fields_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !det_pulse |-> $stable({det_msg_type, det_seq_id, det_encap, det_tags}));

    p_pulse_after_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
        det_pulse |-> $past(rx_dv));

    p_encap_known_r2: assert property (@(posedge clk) disable iff (!rst_n)
        det_pulse |-> det_encap != 2'd3);

    p_tags_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        det_pulse |-> det_tags <= TAG_W'(MAX_TAGS));

    p_handover_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({go_l2, go_ip4, go_ip6, go_ptp}));

    p_handover_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (go_ip4 | go_ip6 | go_l2) |-> $past(rx_dv));

endmodule

bind ptp_frame_sniffer psn_checker #(.MAX_TAGS(MAX_TAGS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_dv        (rx_dv),
    .det_pulse    (det_pulse),
    .det_msg_type (det_msg_type),
    .det_seq_id   (det_seq_id),
    .det_encap    (det_encap),
    .det_tags     (det_tags),
    .go_l2        (go_l2),
    .go_ip4       (go_ip4),
    .go_ip6       (go_ip6),
    .go_ptp       (go_ptp)
);

// File: tb/sim_ptp_frame_sniffer.sv
module sim_ptp_frame_sniffer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_dv = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        det_pulse;
    logic [3:0]  det_msg_type;
    logic [15:0] det_seq_id;
    logic [1:0]  det_encap;
    logic [1:0]  det_tags;

    ptp_frame_sniffer u0 (
        .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_byte(rx_byte),
        .det_pulse(det_pulse), .det_msg_type(det_msg_type),
        .det_seq_id(det_seq_id), .det_encap(det_encap), .det_tags(det_tags)
    );

    always #10 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0] fr [0:127];
    int  fr_len, ptp_off;
    bit  exp_hit;
    string cause;
    int  e_mt, e_seq, e_enc, e_tags;
    int  last_mt = 0, last_seq = 0, last_enc = 0, last_tags = 0;
    int  n_hit, hit_k, h_mt, h_seq, h_enc, h_tags;

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // kind: 0 Ethernet PTP, 1 IPv4, 2 IPv6, 3 other ethertype
    // trunc: 0 full, 1 ends after PTP byte 30, 2 ends after byte 31, 3 random short
    task automatic build(input int tags, input int kind, input logic [7:0] vihl,
                         input logic [7:0] proto, input logic [15:0] dport,
                         input logic [3:0] mt, input logic [15:0] seq, input int trunc);
        int p, ip, udp;
        for (int i = 0; i < 128; i++) fr[i] = 8'($urandom);
        p = 12;
        for (int t = 0; t < tags; t++) begin
            fr[p] = 8'h81; fr[p+1] = 8'h00; p += 4;
        end
        case (kind)
            0: begin fr[p] = 8'h88; fr[p+1] = 8'hF7; end
            1: begin fr[p] = 8'h08; fr[p+1] = 8'h00; end
            2: begin fr[p] = 8'h86; fr[p+1] = 8'hDD; end
            default: begin fr[p] = 8'h08; fr[p+1] = 8'h06; end
        endcase
        ip = p + 2;
        ptp_off = ip;
        if (kind == 1) begin
            fr[ip] = vihl; fr[ip+9] = proto; udp = ip + 20;
        end else begin
            fr[ip] = 8'h60; fr[ip+6] = proto; udp = ip + 40;
        end
        if (kind == 1 || kind == 2) begin
            fr[udp+2] = dport[15:8]; fr[udp+3] = dport[7:0]; ptp_off = udp + 8;
        end
        fr[ptp_off] = {4'($urandom), mt};
        fr[ptp_off+30] = seq[15:8];
        fr[ptp_off+31] = seq[7:0];
        case (trunc)
            1: fr_len = ptp_off + 31;
            2: fr_len = ptp_off + 32;
            3: fr_len = 14 + int'($urandom % 32'(ptp_off + 31 - 14));
            default: fr_len = ptp_off + 44;
        endcase
        exp_hit = 1; cause = "";
        if (tags > 2) begin exp_hit = 0; cause = "R3"; end
        else if (kind == 3) begin exp_hit = 0; cause = "R9"; end
        else if (kind == 1 && vihl != 8'h45) begin exp_hit = 0; cause = "R4"; end
        else if (kind != 0 && proto != 8'd17) begin exp_hit = 0; cause = (kind == 1) ? "R4" : "R5"; end
        else if (kind != 0 && dport != 16'd319 && dport != 16'd320) begin exp_hit = 0; cause = "R6"; end
        else if (fr_len < ptp_off + 32) begin exp_hit = 0; cause = "R9"; end
        e_mt = int'(mt); e_seq = int'(seq); e_enc = kind; e_tags = tags;
    endtask

    task automatic sample(input int k);
        if (det_pulse) begin
            n_hit++; hit_k = k;
            h_mt = int'(det_msg_type); h_seq = int'(det_seq_id);
            h_enc = int'(det_encap); h_tags = int'(det_tags);
        end
    endtask

    task automatic send_and_check(input int gap, input string cnt_req);
        string rq;
        n_hit = 0; hit_k = -1;
        for (int i = 0; i < fr_len; i++) begin
            @(negedge clk); sample(i);
            rx_dv = 1'b1; rx_byte = fr[i];
        end
        for (int g = 0; g < gap; g++) begin
            @(negedge clk); sample(fr_len + g);
            rx_dv = 1'b0; rx_byte = 8'h00;
        end
        if (exp_hit) begin
            rq = (cnt_req != "") ? cnt_req : ((e_enc == 0) ? "R2" : "R6");
            chk(rq, "pulse count", n_hit, 1);
            chk("R8", "pulse cycle", hit_k, ptp_off + 32);
            chk("R7", "msg type", h_mt, e_mt);
            chk("R7", "seq id", h_seq, e_seq);
            chk((e_enc == 0) ? "R2" : ((e_enc == 1) ? "R4" : "R5"), "encap", h_enc, e_enc);
            chk("R3", "tags", h_tags, e_tags);
            last_mt = e_mt; last_seq = e_seq; last_enc = e_enc; last_tags = e_tags;
        end else begin
            rq = (cnt_req != "") ? cnt_req : cause;
            chk(rq, "pulse count", n_hit, 0);
            chk("R8", "held seq id", int'(det_seq_id), last_seq);
            chk("R8", "held msg type", int'(det_msg_type), last_mt);
        end
    endtask

    initial begin
        void'($urandom(32'd1588));
        repeat (3) @(negedge clk);
        chk("R1", "pulse in reset", int'(det_pulse), 0);
        chk("R1", "seq in reset", int'(det_seq_id), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "pulse after reset", int'(det_pulse), 0);
        chk("R1", "fields after reset", int'({det_msg_type, det_encap, det_tags}), 0);

        build(0, 0, 8'h45, 8'd17, 16'd319, 4'h0, 16'h1234, 0); send_and_check(2, "R2");
        build(1, 0, 8'h45, 8'd17, 16'd319, 4'h8, 16'hBEEF, 0); send_and_check(2, "R3");
        build(2, 0, 8'h45, 8'd17, 16'd319, 4'h3, 16'h00FF, 0); send_and_check(2, "R3");
        build(3, 0, 8'h45, 8'd17, 16'd319, 4'h1, 16'h4444, 0); send_and_check(2, "R3");
        build(0, 1, 8'h45, 8'd17, 16'd319, 4'h1, 16'hA5A5, 0); send_and_check(2, "R4");
        build(2, 1, 8'h45, 8'd17, 16'd320, 4'hB, 16'h0001, 0); send_and_check(2, "R6");
        build(0, 1, 8'h46, 8'd17, 16'd319, 4'h1, 16'h7777, 0); send_and_check(2, "R4");
        build(0, 1, 8'h45, 8'd6,  16'd319, 4'h1, 16'h7778, 0); send_and_check(2, "R4");
        build(1, 2, 8'h45, 8'd17, 16'd320, 4'h2, 16'hFFFF, 0); send_and_check(2, "R5");
        build(0, 2, 8'h45, 8'd6,  16'd319, 4'h2, 16'h1111, 0); send_and_check(2, "R5");
        build(0, 1, 8'h45, 8'd17, 16'd321, 4'h0, 16'h2222, 0); send_and_check(2, "R6");
        build(0, 2, 8'h45, 8'd17, 16'd318, 4'h0, 16'h3333, 0); send_and_check(2, "R6");
        build(0, 3, 8'h45, 8'd17, 16'd319, 4'h0, 16'h5555, 0); send_and_check(2, "R9");
        build(1, 1, 8'h45, 8'd17, 16'd319, 4'h9, 16'h6666, 1); send_and_check(3, "R9");
        build(1, 1, 8'h45, 8'd17, 16'd319, 4'h9, 16'h6667, 2); send_and_check(3, "R9");
        build(0, 0, 8'h45, 8'd17, 16'd319, 4'h4, 16'h0A0A, 0); send_and_check(1, "R10");
        build(2, 2, 8'h45, 8'd17, 16'd319, 4'h5, 16'h0B0B, 0); send_and_check(1, "R10");
        build(0, 1, 8'h45, 8'd17, 16'd320, 4'h6, 16'h0C0C, 0); send_and_check(1, "R10");

        for (int n = 0; n < 300; n++) begin
            int tg, kd, tr, pr;
            logic [15:0] dp;
            tg = int'($urandom % 4);
            kd = int'($urandom % 4);
            pr = int'($urandom % 8);
            dp = (pr == 0) ? 16'd321 : ((pr == 1) ? 16'd318 : (($urandom % 2) ? 16'd319 : 16'd320));
            tr = ($urandom % 6 == 0) ? int'(1 + $urandom % 3) : 0;
            build(tg, kd, ($urandom % 8 == 0) ? 8'h46 : 8'h45,
                  ($urandom % 8 == 0) ? 8'd6 : 8'd17, dp,
                  4'($urandom), 16'($urandom), tr);
            send_and_check(1 + int'($urandom % 3), "");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule